// File: doc/BRIEF.md
# Serial Display Column Memory Port

This block is the host-facing side of a multiplexed dot-matrix display driver. A controller talks to it over a four-wire serial link: an active-low select, a serial clock, a data input and a data output that idles high like a released open-drain line. Every exchange is a fixed 30-bit frame. The frame names a starting column and a direction, and then moves three 8-row columns of the display picture into or out of an internal 24-column memory. One reserved address turns the frame into a configuration write that sets the number of driven backplanes and whether the driver generates its own backplane timing or follows another driver.

All four serial pins are brought into the system clock domain through a small synchroniser, and their edges are detected there. The drive-waveform sequencer reads the picture through a combinational scan port, one column at a time, and it takes the configuration from two mode outputs. The serial link must be slow against the system clock: each serial half-period has to last several system clock cycles.

Top module: `ser_disp_port`

## Requirements
- R1: A frame starts when `ser_csn` falls while no frame is in progress, and it consists of exactly 30 rising edges of `ser_clk`. Edges of `ser_clk` while no frame is in progress are ignored.
- R2: The bits of a frame are taken on rising `ser_clk` edges in this order: 5 address bits with the most significant bit first, then the direction flag (0 = write, 1 = read), then 24 data bits numbered 0 to 23.
- R3: A write frame with an address `a` from 0 to 23 replaces columns `a`, `(a+1) mod 24` and `(a+2) mod 24`. Data bit `8*c + r` lands in row `r` of column `(a+c) mod 24`, and row `r` appears on `scan_bits[r]`. All other columns are kept.
- R4: A read frame with an address from 0 to 23 presents data bit `j` on `ser_dout` after the falling edge of clock `7+j`. The bit mapping is the same as in R3, and the memory is not changed.
- R5: Once a frame has started, `ser_csn` may return high at any time; the frame still runs to its 30th clock and takes full effect.
- R6: A write frame to address 24 is a mode frame. Data bit 0 goes to `bp_sel[2]`, bit 1 to `bp_sel[1]`, bit 2 to `bp_sel[0]` and bit 3 to `is_master`. The new values appear only after the 30th clock. Data bits 4 to 23 and the memory are left untouched.
- R7: A read frame to address 24 and any frame to addresses 25 to 31 change neither the memory nor the mode outputs, and `ser_dout` stays high for the whole frame.
- R8: During a write frame, each column is written into memory as soon as its eighth bit has been taken, before the next column's bits arrive.
- R9: After reset the memory holds all zeros, `bp_sel` is 0, `is_master` is 0 and `ser_dout` is 1.
- R10: `ser_dout` is 1 outside read data. After a read frame it keeps its final bit until `ser_csn` rises with no frame in progress, or until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_csn | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data, 1 when released |
| scan_col | input | 5 | Column index for the drive sequencer |
| scan_bits | output | 8 | Rows of the selected column, 0 beyond the last column |
| bp_sel | output | 3 | Backplane-count select code |
| is_master | output | 1 | 1 = generate own backplane timing |

## Verification
The bench builds the block with its defaults: 24 columns, 8 rows, a 5-bit address and a two-stage synchroniser. This configuration is small enough to sweep every one of the 32 addresses, including every wrap position of a three-column transfer, in both directions, and to apply all eight select codes with both master settings. Because the synchroniser latency is that of the default build, the bench can also check a column commit in the middle of a frame, the release of chip select just after the first clock, and how long the last read bit is held.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
package sdp_pkg;

   typedef enum logic [1:0] {
      FK_NONE  = 2'd0,
      FK_WRITE = 2'd1,
      FK_READ  = 2'd2,
      FK_MODE  = 2'd3
   } frame_kind_e;

   localparam int MODE_CODE_W = 3;

endpackage

// File: rtl/sdp_sync.sv
`timescale 1ns/1ps
module sdp_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] sh_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) sh_q[i] <= RST_VAL;
            end else begin
               sh_q[0] <= d;
               for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sdp_framer.sv
`timescale 1ns/1ps
module sdp_framer
   import sdp_pkg::*;
#(
   parameter int COLS      = 24,
   parameter int ROWS      = 8,
   parameter int ADDR_W    = 5,
   parameter int GROUP     = 3,
   parameter int MODE_ADDR = 24
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rise_i,
   input  logic                               cs_fall_i,
   input  logic                               din_i,
   output logic                               active_o,
   output frame_kind_e                        kind_o,
   output logic [$clog2(ADDR_W+2+GROUP*ROWS)-1:0] cnt_o,
   output logic                               data_vld_o,
   output logic                               data_bit_o,
   output logic [$clog2(GROUP*ROWS+1)-1:0]    idx_o,
   output logic [$clog2(COLS)-1:0]            col_o,
   output logic [$clog2(ROWS)-1:0]            row_o,
   output logic                               end_o
);

   localparam int DATA_BITS = GROUP * ROWS;
   localparam int FRAME_LEN = ADDR_W + 1 + DATA_BITS;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam int IDX_W     = $clog2(DATA_BITS + 1);
   localparam int COL_W     = $clog2(COLS);
   localparam int ROW_W     = $clog2(ROWS);

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   frame_kind_e       kind_q, kind_d;
   logic [IDX_W-1:0]  idx_q;
   logic [COL_W-1:0]  col_q;
   logic [ROW_W-1:0]  row_q;

   logic take, in_addr, at_flag, in_data, addr_ok;

   assign take    = active_q & rise_i;
   assign in_addr = cnt_q <  CNT_W'(ADDR_W);
   assign at_flag = cnt_q == CNT_W'(ADDR_W);
   assign in_data = cnt_q >  CNT_W'(ADDR_W);
   assign addr_ok = addr_q < ADDR_W'(COLS);

   // frame class is settled by the address and the direction flag
   always_comb begin
      if (addr_ok)
         kind_d = din_i ? FK_READ : FK_WRITE;
      else if (addr_q == ADDR_W'(MODE_ADDR) && !din_i)
         kind_d = FK_MODE;
      else
         kind_d = FK_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         addr_q   <= '0;
         kind_q   <= FK_NONE;
         idx_q    <= '0;
         col_q    <= '0;
         row_q    <= '0;
      end else if (!active_q) begin
         if (cs_fall_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            addr_q   <= '0;
            kind_q   <= FK_NONE;
         end
      end else if (rise_i) begin
         cnt_q <= cnt_q + 1'b1;
         if (in_addr) begin
            addr_q <= {addr_q[ADDR_W-2:0], din_i};
         end else if (at_flag) begin
            kind_q <= kind_d;
            col_q  <= addr_ok ? addr_q[COL_W-1:0] : '0;
            row_q  <= '0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
            if (row_q == ROW_W'(ROWS-1)) begin
               row_q <= '0;
               col_q <= (col_q == COL_W'(COLS-1)) ? '0 : col_q + 1'b1;
            end else begin
               row_q <= row_q + 1'b1;
            end
         end
         if (cnt_q == CNT_W'(FRAME_LEN-1)) active_q <= 1'b0;
      end
   end

   assign active_o   = active_q;
   assign kind_o     = kind_q;
   assign cnt_o      = cnt_q;
   assign data_vld_o = take & in_data;
   assign data_bit_o = din_i;
   assign idx_o      = idx_q;
   assign col_o      = col_q;
   assign row_o      = row_q;
   assign end_o      = take & (cnt_q == CNT_W'(FRAME_LEN-1));

endmodule

// File: rtl/sdp_colmem.sv
`timescale 1ns/1ps
module sdp_colmem #(
   parameter int COLS = 24,
   parameter int ROWS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_vld,
   input  logic                    wr_bit,
   input  logic [$clog2(COLS)-1:0] wr_col,
   input  logic [$clog2(ROWS)-1:0] wr_row,
   output logic                    commit_o,
   input  logic [$clog2(COLS)-1:0] rd_col,
   input  logic [$clog2(ROWS)-1:0] rd_row,
   output logic                    rd_bit,
   input  logic [$clog2(COLS)-1:0] scan_col,
   output logic [ROWS-1:0]         scan_bits
);

   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);

   logic [ROWS-1:0] mem_q [COLS];
   logic [ROWS-2:0] part_q;
   logic            last_row;

   assign last_row = wr_row == ROW_W'(ROWS-1);
   assign commit_o = wr_vld & last_row;

   // rows gather in a staging register; the column lands on its last row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < COLS; c++) mem_q[c] <= '0;
         part_q <= '0;
      end else if (wr_vld) begin
         if (last_row) mem_q[wr_col] <= {wr_bit, part_q};
         else          part_q[wr_row] <= wr_bit;
      end
   end

   assign rd_bit    = mem_q[rd_col][rd_row];
   assign scan_bits = ({1'b0, scan_col} < (COL_W+1)'(COLS)) ? mem_q[scan_col] : '0;

endmodule

// File: rtl/ser_disp_port.sv
`timescale 1ns/1ps
module ser_disp_port
   import sdp_pkg::*;
#(
   parameter int COLS        = 24,
   parameter int ROWS        = 8,
   parameter int ADDR_W      = 5,
   parameter int GROUP       = 3,
   parameter int MODE_ADDR   = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_clk,
   input  logic                    ser_csn,
   input  logic                    ser_din,
   output logic                    ser_dout,
   input  logic [$clog2(COLS)-1:0] scan_col,
   output logic [ROWS-1:0]         scan_bits,
   output logic [MODE_CODE_W-1:0]  bp_sel,
   output logic                    is_master
);

   localparam int DATA_BITS = GROUP * ROWS;
   localparam int FRAME_LEN = ADDR_W + 1 + DATA_BITS;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam int IDX_W     = $clog2(DATA_BITS + 1);
   localparam int COL_W     = $clog2(COLS);
   localparam int ROW_W     = $clog2(ROWS);

   generate
      if (COLS >= 2**ADDR_W || MODE_ADDR < COLS || MODE_ADDR >= 2**ADDR_W ||
          ROWS < 2 || ADDR_W < 2 || DATA_BITS < MODE_CODE_W + 1) begin : g_bad_cfg
         $error("ser_disp_port: parameter set out of range");
      end
   endgenerate

   // ---- pin synchronisation and edge detection
   logic [2:0] s_vec;
   logic       p_clk, p_csn;
   logic       ev_rise, ev_fall, ev_cs_fall, ev_cs_rise;

   sdp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ser_din, ser_csn, ser_clk}), .q(s_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_clk <= 1'b0;
         p_csn <= 1'b1;
      end else begin
         p_clk <= s_vec[0];
         p_csn <= s_vec[1];
      end
   end

   assign ev_rise    =  s_vec[0] & ~p_clk;
   assign ev_fall    = ~s_vec[0] &  p_clk;
   assign ev_cs_fall = ~s_vec[1] &  p_csn;
   assign ev_cs_rise =  s_vec[1] & ~p_csn;

   // ---- frame decode
   logic              f_active, f_vld, f_bit, f_end;
   frame_kind_e       f_kind;
   logic [CNT_W-1:0]  f_cnt;
   logic [IDX_W-1:0]  f_idx;
   logic [COL_W-1:0]  f_col;
   logic [ROW_W-1:0]  f_row;

   sdp_framer #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W), .GROUP(GROUP),
                .MODE_ADDR(MODE_ADDR)) u_framer (
      .clk(clk), .rst_n(rst_n), .rise_i(ev_rise), .cs_fall_i(ev_cs_fall),
      .din_i(s_vec[2]), .active_o(f_active), .kind_o(f_kind), .cnt_o(f_cnt),
      .data_vld_o(f_vld), .data_bit_o(f_bit), .idx_o(f_idx), .col_o(f_col),
      .row_o(f_row), .end_o(f_end));

   // ---- picture memory
   logic m_commit, m_rd_bit;

   sdp_colmem #(.COLS(COLS), .ROWS(ROWS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_vld(f_vld && f_kind == FK_WRITE), .wr_bit(f_bit),
      .wr_col(f_col), .wr_row(f_row), .commit_o(m_commit),
      .rd_col(f_col), .rd_row(f_row), .rd_bit(m_rd_bit),
      .scan_col(scan_col), .scan_bits(scan_bits));

   // ---- mode register: staged during the frame, applied on its last clock
   logic [MODE_CODE_W-1:0] code_stage, bp_q;
   logic                   mst_stage, master_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_stage <= '0;
         mst_stage  <= 1'b0;
         bp_q       <= '0;
         master_q   <= 1'b0;
      end else begin
         if (f_vld && f_kind == FK_MODE) begin
            if (f_idx < IDX_W'(MODE_CODE_W))
               code_stage[MODE_CODE_W-1 - int'(f_idx)] <= f_bit;
            else if (f_idx == IDX_W'(MODE_CODE_W))
               mst_stage <= f_bit;
         end
         if (f_end && f_kind == FK_MODE) begin
            bp_q     <= code_stage;
            master_q <= mst_stage;
         end
      end
   end

   // ---- read path: bit fetched at the rising edge, shown at the falling edge
   logic pend_q, armed_q, dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
         dout_q  <= 1'b1;
      end else begin
         if (f_vld && f_kind == FK_READ) begin
            pend_q  <= m_rd_bit;
            armed_q <= 1'b1;
         end
         if (!f_active && (ev_cs_fall || ev_cs_rise)) dout_q <= 1'b1;
         if (ev_fall && armed_q) begin
            dout_q  <= pend_q;
            armed_q <= 1'b0;
         end
      end
   end

   assign ser_dout  = dout_q;
   assign bp_sel    = bp_q;
   assign is_master = master_q;

endmodule

// File: rtl/sdp_chk.sv
`timescale 1ns/1ps
module sdp_chk
   import sdp_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int FRAME_LEN = 30,
   parameter int CNT_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             active,
   input frame_kind_e      kind,
   input logic [CNT_W-1:0] cnt,
   input logic             frame_end,
   input logic             commit,
   input logic             fall,
   input logic             cs_fall,
   input logic             cs_rise,
   input logic             dout,
   input logic [2:0]       bp_sel,
   input logic             is_master
);

   // R1: a frame closes only after its full count of clocks
   assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> cnt == CNT_W'(FRAME_LEN));

   // R3, R4: memory columns are committed only inside write frames
   assert_commit_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (active && kind == FK_WRITE));

   // R6: the mode outputs move only when a mode frame ends
   assert_mode_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ({bp_sel, is_master} != $past({bp_sel, is_master})) |->
         $past(frame_end && kind == FK_MODE));

   // R7: an ignored frame keeps the data line released
   assert_idle_dout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && kind == FK_NONE && cnt > CNT_W'(ADDR_W + 1)) |-> dout);

   // R10: the data line moves only on a serial falling edge or select edge
   assert_dout_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> $past(fall || cs_fall || cs_rise));

endmodule

bind ser_disp_port sdp_chk #(.ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(f_active), .kind(f_kind), .cnt(f_cnt),
   .frame_end(f_end), .commit(m_commit), .fall(ev_fall), .cs_fall(ev_cs_fall),
   .cs_rise(ev_cs_rise), .dout(ser_dout), .bp_sel(bp_sel), .is_master(is_master));

// File: tb/ser_disp_port_bench.sv
`timescale 1ns/1ps
module ser_disp_port_bench;

   localparam int NCOL = 24;
   localparam int HP   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_csn = 1'b1;
   logic       ser_din = 1'b0;
   logic       ser_dout;
   logic [4:0] scan_col = '0;
   logic [7:0] scan_bits;
   logic [2:0] bp_sel;
   logic       is_master;

   int total = 0;
   int bad   = 0;
   logic [7:0] model [NCOL];
   logic [2:0] exp_code = '0;
   logic       exp_mst  = 1'b0;

   always #2.5 clk = ~clk;

   ser_disp_port u_ser_disp_port (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
      .ser_din(ser_din), .ser_dout(ser_dout), .scan_col(scan_col),
      .scan_bits(scan_bits), .bp_sel(bp_sel), .is_master(is_master));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_mem(input string tag);
      bit ok = 1'b1;
      logic [7:0] a_v = '0, e_v = '0;
      for (int c = 0; c < NCOL; c++) begin
         scan_col = 5'(c);
         #1;
         if (ok && scan_bits !== model[c]) begin
            ok = 1'b0; a_v = scan_bits; e_v = model[c];
         end
      end
      chk(ok, tag, 32'(a_v), 32'(e_v));
   endtask

   function automatic logic [23:0] expect_read(input int a);
      logic [23:0] r;
      for (int j = 0; j < 24; j++) r[j] = model[(a + j/8) % NCOL][j%8];
      return r;
   endfunction

   function automatic void apply_write(input int a, input logic [23:0] dat);
      for (int c = 0; c < 3; c++) model[(a + c) % NCOL] = dat[8*c +: 8];
   endfunction

   // one complete frame; cs_up = clock after which select returns high,
   // pause_k = clock after which the R8 mid-frame commit is inspected
   task automatic send(input logic [4:0] a, input logic rw, input logic [23:0] dat,
                       input int cs_up, input int pause_k, input bit hold_low,
                       output logic [23:0] rd);
      logic v;
      rd = '1;
      @(negedge clk);
      ser_csn = 1'b0;
      tick(HP);
      for (int k = 1; k <= 30; k++) begin
         if (k <= 5)      v = a[5-k];
         else if (k == 6) v = rw;
         else             v = dat[k-7];
         ser_din = v;
         tick(2);
         ser_clk = 1'b1;
         tick(HP);
         if (k == cs_up) ser_csn = 1'b1;
         ser_clk = 1'b0;
         tick(HP-2);
         if (k >= 7) rd[k-7] = ser_dout;
         if (k == pause_k) begin
            scan_col = a; #1;
            chk(scan_bits === dat[7:0], "R8 first column committed mid-frame",
                32'(scan_bits), 32'(dat[7:0]));
            scan_col = 5'((a + 1) % NCOL); #1;
            chk(scan_bits === model[(a + 1) % NCOL], "R8 next column not yet written",
                32'(scan_bits), 32'(model[(a + 1) % NCOL]));
         end
      end
      tick(HP);
      if (!hold_low) begin
         ser_csn = 1'b1;
         tick(HP);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [23:0] rd, dat, expv;
      for (int c = 0; c < NCOL; c++) model[c] = '0;
      tick(4);
      rst_n = 1'b1;
      tick(4);

      // R9 reset state
      chk(ser_dout === 1'b1, "R9 dout after reset", 32'(ser_dout), 32'd1);
      chk(bp_sel === 3'd0 && is_master === 1'b0, "R9 mode after reset",
          32'({bp_sel, is_master}), 32'd0);
      check_mem("R9 memory cleared");

      // R1 serial clocks with select high are ignored
      ser_din = 1'b1;
      for (int i = 0; i < 40; i++) begin
         ser_clk = ~ser_clk;
         tick(HP);
      end
      ser_clk = 1'b0;
      ser_din = 1'b0;
      tick(HP);
      check_mem("R1 idle clocks ignored");
      chk(ser_dout === 1'b1, "R1 dout idle", 32'(ser_dout), 32'd1);

      // R2 R3 write sweep over every start column, including the wrap
      for (int a = 0; a < NCOL; a++) begin
         dat = {8'(a*29 + 3), 8'(a*13 + 5) ^ 8'h5A, 8'(a*7 + 1) ^ 8'hC3};
         send(5'(a), 1'b0, dat, 0, 0, 1'b0, rd);
         apply_write(a, dat);
         check_mem($sformatf("R3 R2 write start=%0d", a));
         chk(rd === 24'hFFFFFF, $sformatf("R10 dout released in write %0d", a),
             32'(rd), 32'hFFFFFF);
      end

      // R4 read sweep
      for (int a = 0; a < NCOL; a++) begin
         expv = expect_read(a);
         send(5'(a), 1'b1, 24'hA5A5A5, 0, 0, 1'b0, rd);
         chk(rd === expv, $sformatf("R4 read start=%0d", a), 32'(rd), 32'(expv));
      end
      check_mem("R4 reads leave memory");

      // R6 mode frames, all codes
      for (int m = 0; m < 8; m++) begin
         exp_code = 3'(m);
         exp_mst  = m[0] ^ m[1];
         dat = {16'hFFFF, 4'hF, exp_mst, exp_code[0], exp_code[1], exp_code[2]};
         send(5'd24, 1'b0, dat, 0, 0, 1'b0, rd);
         chk(bp_sel === exp_code && is_master === exp_mst,
             $sformatf("R6 mode frame %0d", m), 32'({bp_sel, is_master}),
             32'({exp_code, exp_mst}));
      end
      check_mem("R6 mode frames leave memory");

      // R7 read at the mode address and frames at reserved addresses
      send(5'd24, 1'b1, 24'h000000, 0, 0, 1'b0, rd);
      chk(rd === 24'hFFFFFF, "R7 mode read gives released line", 32'(rd), 32'hFFFFFF);
      for (int a = 25; a < 32; a++) begin
         send(5'(a), 1'b0, 24'h123456 ^ 24'(a), 0, 0, 1'b0, rd);
         send(5'(a), 1'b1, 24'h000000, 0, 0, 1'b0, rd);
         chk(rd === 24'hFFFFFF, $sformatf("R7 reserved read %0d", a), 32'(rd), 32'hFFFFFF);
      end
      check_mem("R7 reserved frames leave memory");
      chk(bp_sel === exp_code && is_master === exp_mst, "R7 mode unchanged",
          32'({bp_sel, is_master}), 32'({exp_code, exp_mst}));

      // R5 select released early
      dat = 24'h3C_81_E7;
      send(5'd5, 1'b0, dat, 1, 0, 1'b0, rd);
      apply_write(5, dat);
      check_mem("R5 write completes after early select release");
      expv = expect_read(4);
      send(5'd4, 1'b1, 24'h0, 3, 0, 1'b0, rd);
      chk(rd === expv, "R5 read completes after early select release",
          32'(rd), 32'(expv));

      // R8 per-column commit, across the wrap point
      dat = 24'h96_4B_D2;
      send(5'd22, 1'b0, dat, 0, 14, 1'b0, rd);
      apply_write(22, dat);
      check_mem("R8 full frame after mid check");

      // R10 last read bit held while select stays low
      dat = 24'h7F_00_FF;
      send(5'd9, 1'b0, dat, 0, 0, 1'b0, rd);
      apply_write(9, dat);
      expv = expect_read(9);
      send(5'd9, 1'b1, 24'h0, 0, 0, 1'b1, rd);
      chk(rd === expv, "R10 read before hold", 32'(rd), 32'(expv));
      tick(3*HP);
      chk(ser_dout === 1'b0, "R10 final bit held", 32'(ser_dout), 32'd0);
      ser_csn = 1'b1;
      tick(HP);
      chk(ser_dout === 1'b1, "R10 released on select rise", 32'(ser_dout), 32'd1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule